// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache controller between a processor word port and a lower memory that moves whole blocks. Every set has two ways. Each way stores a tag, a valid flag, a dirty flag and a block of several words. A request looks up both ways of the indexed set at once. A hit answers in the same cycle it is presented. Processor writes change only the cached copy and mark the line dirty.

On a miss, the controller lowers `cpu_req_ready` and picks a victim. An empty way is taken first. If both ways are full, the way used least recently in that set is taken, tracked by one bit per set. A dirty victim is first copied into a one-entry holding register. The controller then fetches the missing block and only afterwards writes the held block to memory. While that write is still in progress, the processor can keep hitting in the cache.

Top module: `assoc2_wb_cache`

## Requirements
- R1: A byte address splits, from the top down, into tag (bits 31:10), set index (bits 9:4), word select (bits 3:2) and ignored byte bits (1:0). A read that hits raises `cpu_req_ready` in the same cycle and returns the selected word on `cpu_rdata`.
- R2: A hit needs a valid way whose stored tag equals the request tag. Any other lookup is a miss and issues exactly one block read.
- R3: Two blocks with the same index and different tags stay resident together, and neither access then reaches memory.
- R4: When a block is allocated into a set that has an empty way, the empty way is filled (way 0 if both are empty) and no resident block is displaced.
- R5: When both ways are valid, the way touched least recently by a hit or a refill is replaced.
- R6: A processor write that hits updates only the cached word, marks the line dirty and causes no memory transfer.
- R7: A clean victim is dropped without any block write.
- R8: A dirty victim is sent downstream only after the refill read has been acknowledged. The block write carries the victim's block address (offset bits zero) and the data most recently written to it.
- R9: From a miss until the refilled line is in place, `cpu_req_ready` stays low. A write miss first allocates the block and then stores its word.
- R10: While a pending block write awaits acknowledgement, processor hits are still served without stalling.
- R11: A block read or write request stays high, with an unchanged address, until its acknowledge arrives.
- R12: Reset clears every valid, dirty and recency bit. After reset, every access misses, and dirty data held before the reset is never written out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor request present; hold it and its fields until accepted |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_req_we | input | 1 | 1 for a write, 0 for a read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while a read is accepted |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_addr | output | 32 | Block-aligned read address |
| mem_rd_ack | input | 1 | One-cycle read acknowledge, data valid with it |
| mem_rd_data | input | 128 | Refill block, word 0 in the low bits |
| mem_wr_req | output | 1 | Block write request |
| mem_wr_addr | output | 32 | Block-aligned write address |
| mem_wr_data | output | 128 | Block being written back |
| mem_wr_ack | input | 1 | One-cycle write acknowledge |

## Verification
The bench builds the block with its default parameters: four 32-bit words per block, 64 sets and 32-bit addresses. Random traffic is limited to six tags over sets 0, 1, 2 and 63. This produces frequent conflicts, so replacement of both clean and dirty victims is exercised heavily, and the top set index is covered as well. Directed cases vary the memory acknowledge delay. A long write delay holds the pending write-back open, so hits can be seen overlapping it, and a mid-run reset discards dirty lines.

// File: rtl/acw_pkg.sv
package acw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } acw_state_e;
endpackage

// File: rtl/acw_way.sv
module acw_way #(
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          lk_idx,
  input  logic [TAG_W-1:0]          lk_tag,
  output logic                      lk_hit,
  output logic                      lk_valid,
  output logic                      lk_dirty,
  output logic [TAG_W-1:0]          lk_tag_o,
  output logic [DATA_W*WORDS-1:0]   lk_blk,
  input  logic                      fill_en,
  input  logic [IDX_W-1:0]          fill_idx,
  input  logic [TAG_W-1:0]          fill_tag,
  input  logic [DATA_W*WORDS-1:0]   fill_blk,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [OFF_W-1:0]          wr_off,
  input  logic [DATA_W-1:0]         wr_data
);
  localparam int BLK_W = DATA_W * WORDS;

  logic [SETS-1:0]  valid_q, valid_d;
  logic [SETS-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [BLK_W-1:0] data_q [SETS];

  // flag next-state
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      dirty_d[fill_idx] = 1'b0;
    end else if (wr_en) begin
      dirty_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en || wr_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  // tag and data storage, not reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_blk;
    end else if (wr_en) begin
      data_q[wr_idx][wr_off*DATA_W +: DATA_W] <= wr_data;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];
  assign lk_tag_o = tag_q[lk_idx];
  assign lk_blk   = data_q[lk_idx];
  assign lk_hit   = lk_valid && (tag_q[lk_idx] == lk_tag);

  // R6: processor writes only land on resident lines
  p_write_resident_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> valid_q[wr_idx]);

  // R7: a freshly refilled line is valid and clean
  p_fill_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));

  p_one_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && wr_en));
endmodule

// File: rtl/acw_lru.sv
module acw_lru #(
  parameter int SETS  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [1:0]       lk_valid,
  output logic             vic_way,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way
);
  // one bit per set naming the way to replace next
  logic [SETS-1:0] old_q, old_d;

  always_comb begin
    old_d = old_q;
    if (touch_en) old_d[touch_idx] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        old_q <= '0;
    else if (touch_en) old_q <= old_d;
  end

  always_comb begin
    if (!lk_valid[0])      vic_way = 1'b0;
    else if (!lk_valid[1]) vic_way = 1'b1;
    else                   vic_way = old_q[lk_idx];
  end

  // R5: just after a way is touched it is not the choice for that full set
  p_lru_avoid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && (touch_idx == lk_idx)) |=>
      (!($stable(lk_idx) && lk_valid[0] && lk_valid[1]) || (vic_way != $past(touch_way))));
endmodule

// File: rtl/acw_hold.sv
module acw_hold #(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 128
) (
  input  logic              clk,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [BLK_W-1:0]  cap_blk,
  output logic [ADDR_W-1:0] held_addr,
  output logic [BLK_W-1:0]  held_blk
);
  always_ff @(posedge clk) begin
    if (cap_en) begin
      held_addr <= cap_addr;
      held_blk  <= cap_blk;
    end
  end
endmodule

// File: rtl/acw_ctrl.sv
module acw_ctrl
  import acw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  input  logic lk_hit,
  input  logic lk_hit_way,
  input  logic vic_way,
  input  logic vic_valid,
  input  logic vic_dirty,
  input  logic rd_ack,
  input  logic wr_ack,
  output logic req_ready,
  output logic rd_req,
  output logic wr_req,
  output logic fill_en,
  output logic fill_way,
  output logic wr_en,
  output logic touch_en,
  output logic touch_way,
  output logic cap_en
);
  acw_state_e state_q, state_d;
  logic       vic_q, vic_d;
  logic       pend_q, pend_d;

  always_comb begin
    state_d   = state_q;
    vic_d     = vic_q;
    pend_d    = pend_q;
    cap_en    = 1'b0;
    fill_en   = 1'b0;
    rd_req    = (state_q == ST_FILL);
    wr_req    = (state_q == ST_DRAIN);
    req_ready = req_valid && lk_hit && (state_q != ST_FILL);
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !lk_hit) begin
          vic_d   = vic_way;
          pend_d  = vic_valid && vic_dirty;
          cap_en  = vic_valid && vic_dirty;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (rd_ack) begin
          fill_en = 1'b1;
          pend_d  = 1'b0;
          state_d = pend_q ? ST_DRAIN : ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (wr_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vic_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      vic_q   <= vic_d;
      pend_q  <= pend_d;
    end
  end

  assign fill_way  = vic_q;
  assign wr_en     = req_ready && req_we;
  assign touch_en  = req_ready || fill_en;
  assign touch_way = fill_en ? vic_q : lk_hit_way;

  // R8: never both directions at once, and a write-back only follows a refill
  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  p_wr_after_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_ack));
  // R11: requests persist until acknowledged
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req);
  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req);
endmodule

// File: rtl/assoc2_wb_cache.sv
module assoc2_wb_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_we,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [DATA_W-1:0]       cpu_req_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    mem_rd_req,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic                    mem_rd_ack,
  input  logic [DATA_W*WORDS-1:0] mem_rd_data,
  output logic                    mem_wr_req,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [DATA_W*WORDS-1:0] mem_wr_data,
  input  logic                    mem_wr_ack
);
  localparam int BLK_W  = DATA_W * WORDS;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LOW_W  = OFF_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - LOW_W;
  localparam int NWAY   = 2;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off;
  assign req_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = cpu_req_addr[LOW_W +: IDX_W];
  assign req_off = cpu_req_addr[BYTE_W +: OFF_W];

  logic             ctl_fill, ctl_wr, fill_way, touch_en, touch_way, cap_en;
  logic             vic_way, hit_any;
  logic [NWAY-1:0]  way_hit, way_valid, way_dirty, way_fill, way_wr;
  logic [TAG_W-1:0] way_tag [NWAY];
  logic [BLK_W-1:0] way_blk [NWAY];

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    assign way_fill[w] = ctl_fill && (fill_way == 1'(w));
    assign way_wr[w]   = ctl_wr && way_hit[w];
    acw_way #(
      .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
      .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .lk_idx   (req_idx),
      .lk_tag   (req_tag),
      .lk_hit   (way_hit[w]),
      .lk_valid (way_valid[w]),
      .lk_dirty (way_dirty[w]),
      .lk_tag_o (way_tag[w]),
      .lk_blk   (way_blk[w]),
      .fill_en  (way_fill[w]),
      .fill_idx (req_idx),
      .fill_tag (req_tag),
      .fill_blk (mem_rd_data),
      .wr_en    (way_wr[w]),
      .wr_idx   (req_idx),
      .wr_off   (req_off),
      .wr_data  (cpu_req_wdata)
    );
  end

  assign hit_any = |way_hit;

  logic [BLK_W-1:0] sel_blk;
  assign sel_blk   = way_hit[1] ? way_blk[1] : way_blk[0];
  assign cpu_rdata = sel_blk[req_off*DATA_W +: DATA_W];

  acw_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lk_idx    (req_idx),
    .lk_valid  (way_valid),
    .vic_way   (vic_way),
    .touch_en  (touch_en),
    .touch_idx (req_idx),
    .touch_way (touch_way)
  );

  acw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (cpu_req_valid),
    .req_we     (cpu_req_we),
    .lk_hit     (hit_any),
    .lk_hit_way (way_hit[1]),
    .vic_way    (vic_way),
    .vic_valid  (way_valid[vic_way]),
    .vic_dirty  (way_dirty[vic_way]),
    .rd_ack     (mem_rd_ack),
    .wr_ack     (mem_wr_ack),
    .req_ready  (cpu_req_ready),
    .rd_req     (mem_rd_req),
    .wr_req     (mem_wr_req),
    .fill_en    (ctl_fill),
    .fill_way   (fill_way),
    .wr_en      (ctl_wr),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .cap_en     (cap_en)
  );

  acw_hold #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_hold (
    .clk       (clk),
    .cap_en    (cap_en),
    .cap_addr  ({way_tag[vic_way], req_idx, {LOW_W{1'b0}}}),
    .cap_blk   (way_blk[vic_way]),
    .held_addr (mem_wr_addr),
    .held_blk  (mem_wr_data)
  );

  assign mem_rd_addr = {req_tag, req_idx, {LOW_W{1'b0}}};

  // R3: a block is resident in at most one way of its set
  p_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(way_hit[0] && way_hit[1]));
  // R9: no request is accepted while a refill is outstanding
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_rd_req |-> !cpu_req_ready);
  // R11: refill address held while waiting for the acknowledge
  p_rd_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_rd_req && !mem_rd_ack) |=> $stable(mem_rd_addr));
  p_wr_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_wr_req && !mem_wr_ack) |=> ($stable(mem_wr_addr) && $stable(mem_wr_data)));
endmodule

// File: tb/assoc2_wb_cache_bench.sv
`timescale 1ns/1ps
module assoc2_wb_cache_bench;
  localparam int SETS = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_we = 1'b0;
  logic [31:0]  cpu_req_addr = '0;
  logic [31:0]  cpu_req_wdata = '0;
  logic         cpu_req_ready;
  logic [31:0]  cpu_rdata;
  logic         mem_rd_req;
  logic [31:0]  mem_rd_addr;
  logic         mem_rd_ack = 1'b0;
  logic [127:0] mem_rd_data = '0;
  logic         mem_wr_req;
  logic [31:0]  mem_wr_addr;
  logic [127:0] mem_wr_data;
  logic         mem_wr_ack = 1'b0;

  always #2.5 clk = ~clk;

  assoc2_wb_cache u_assoc2_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rdata(cpu_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, rd_delay = 2, wr_delay = 2, rd_wait = 0, wr_wait = 0;
  bit done = 0;
  logic [31:0] rd_first, wr_first;
  logic [127:0] bmem [int];
  logic [31:0]  gword [int];
  logic [31:0]  q_addr [$];
  logic [127:0] q_data [$];
  int           q_mark [$];
  bit m_v [SETS][2];
  bit m_d [SETS][2];
  int m_t [SETS][2];
  bit m_l [SETS];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(int wa);
    logic [31:0] x = 32'(wa);
    return (x * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [127:0] bmem_block(int ba);
    logic [127:0] b;
    if (bmem.exists(ba)) return bmem[ba];
    for (int i = 0; i < 4; i++) b[i*32 +: 32] = init_word(ba*4 + i);
    return b;
  endfunction

  function automatic logic [31:0] gold_word(int wa);
    logic [127:0] b;
    if (gword.exists(wa)) return gword[wa];
    b = bmem_block(wa / 4);
    return b[(wa % 4)*32 +: 32];
  endfunction

  function automatic logic [127:0] gold_block(int ba);
    logic [127:0] b;
    for (int i = 0; i < 4; i++) b[i*32 +: 32] = gold_word(ba*4 + i);
    return b;
  endfunction

  function automatic logic [31:0] mk(int tag, int set, int word, int byt);
    return {22'(tag), 6'(set), 2'(word), 2'(byt)};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m_v[s][0] = 0; m_v[s][1] = 0; m_d[s][0] = 0; m_d[s][1] = 0; m_l[s] = 0;
    end
    gword.delete();
  endtask

  // lower memory: acknowledges after a programmable delay
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_ack = 0; mem_wr_ack = 0; rd_wait = 0; wr_wait = 0;
    end else begin
      if (mem_rd_ack) mem_rd_ack = 0;
      else if (mem_rd_req) begin
        if (rd_wait == 0) rd_first = mem_rd_addr;
        if (rd_wait >= rd_delay) begin
          chk(mem_rd_addr == rd_first, "R11", "read address held", mem_rd_addr, rd_first);
          mem_rd_data = bmem_block(int'(mem_rd_addr >> 4));
          mem_rd_ack = 1; rd_cnt++; rd_wait = 0;
        end else rd_wait++;
      end
      if (mem_wr_ack) mem_wr_ack = 0;
      else if (mem_wr_req) begin
        if (wr_wait == 0) wr_first = mem_wr_addr;
        if (wr_wait >= wr_delay) begin
          chk(mem_wr_addr == wr_first, "R11", "write address held", mem_wr_addr, wr_first);
          bmem[int'(mem_wr_addr >> 4)] = mem_wr_data;
          mem_wr_ack = 1; wr_cnt++; wr_wait = 0;
          if (q_addr.size() == 0) chk(0, "R8", "unexpected block write", mem_wr_addr, 0);
          else begin
            chk(mem_wr_addr == q_addr[0], "R8", "write-back address", mem_wr_addr, q_addr[0]);
            chk(mem_wr_data == q_data[0], "R8", "write-back data", mem_wr_data, q_data[0]);
            chk(rd_cnt == q_mark[0], "R8", "write-back follows refill read", rd_cnt, q_mark[0]);
            void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_mark.pop_front());
          end
        end else wr_wait++;
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input string rq, output bit was_hit);
    int s = int'(a[9:4]);
    int t = int'(a[31:10]);
    int wa = int'(a >> 2);
    int hw = -1;
    int v, r0, st;
    bit pred_hit;
    logic [31:0] ex;
    for (int i = 0; i < 2; i++) if (m_v[s][i] && m_t[s][i] == t) hw = i;
    pred_hit = (hw >= 0);
    ex = gold_word(wa);
    r0 = rd_cnt;
    if (!pred_hit) begin
      v = !m_v[s][0] ? 0 : (!m_v[s][1] ? 1 : int'(m_l[s]));
      if (m_v[s][v] && m_d[s][v]) begin
        q_addr.push_back((32'(m_t[s][v]) << 10) | (32'(s) << 4));
        q_data.push_back(gold_block(m_t[s][v]*SETS + s));
        q_mark.push_back(r0 + 1);
      end
      m_v[s][v] = 1; m_t[s][v] = t; m_d[s][v] = 0; hw = v;
    end
    m_l[s] = (hw == 0);
    if (we) begin m_d[s][hw] = 1; gword[wa] = wd; end
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    #0.5;
    st = 0;
    while (!cpu_req_ready && st < 1000) begin @(negedge clk); #0.5; st++; end
    if (!we) chk(cpu_rdata == ex, rq, "read data", cpu_rdata, ex);
    if (pred_hit) chk(st == 0 && rd_cnt == r0, rq, "hit without stall or refill", st, 0);
    else chk(st > 0 && rd_cnt == r0 + 1, rq, "miss stalls for one refill", rd_cnt - r0, 1);
    was_hit = (st == 0);
    @(posedge clk); #0.5;
    cpu_req_valid = 0; cpu_req_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit h;
    int w0;
    int unsigned sd;
    logic [31:0] fwd;
    sd = $urandom(32'd51966);
    model_clear();
    repeat (4) @(negedge clk);
    #0.5;
    chk(!cpu_req_ready && !mem_rd_req && !mem_wr_req, "R12", "idle outputs in reset",
        {cpu_req_ready, mem_rd_req, mem_wr_req}, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 / R1: cold miss, then same block with other word and byte bits
    access(0, mk(1, 1, 2, 0), 0, "R2", h);
    access(0, mk(1, 1, 3, 3), 0, "R1", h);
    // R4 / R3: second tag fills the empty way, first stays
    w0 = wr_cnt;
    access(0, mk(2, 1, 0, 0), 0, "R4", h);
    access(0, mk(1, 1, 0, 0), 0, "R4", h);
    chk(h, "R3", "both tags resident", h, 1);
    // R6: write hit stays in cache
    access(1, mk(1, 1, 0, 0), 32'hA5A5_0001, "R6", h);
    repeat (8) @(negedge clk);
    chk(wr_cnt == w0, "R6", "no memory write on write hit", wr_cnt, w0);
    // R5 / R7: third tag replaces least recently used clean way
    access(0, mk(3, 1, 1, 0), 0, "R5", h);
    repeat (8) @(negedge clk);
    chk(wr_cnt == w0, "R7", "clean victim dropped", wr_cnt, w0);
    access(0, mk(1, 1, 0, 0), 0, "R5", h);
    chk(h, "R5", "recent way kept", h, 1);
    access(0, mk(2, 1, 2, 0), 0, "R5", h);
    chk(!h, "R5", "old way was replaced", h, 0);
    // R8 / R10: dirty eviction with slow write, hit served meanwhile
    wr_delay = 20;
    w0 = wr_cnt;
    access(0, mk(4, 1, 3, 0), 0, "R8", h);
    access(0, mk(2, 1, 1, 0), 0, "R10", h);
    chk(h && wr_cnt == w0, "R10", "hit during pending write-back", {h, 8'(wr_cnt - w0)}, 9'h100);
    while (wr_cnt == w0) @(negedge clk);
    chk(wr_cnt == w0 + 1, "R8", "one block written back", wr_cnt, w0 + 1);
    wr_delay = 2;
    access(0, mk(1, 1, 0, 0), 0, "R8", h);
    // R9: write miss allocates then stores
    access(1, mk(5, 2, 1, 0), 32'hCAFE_0001, "R9", h);
    chk(!h, "R9", "write miss stalled", h, 0);
    access(0, mk(5, 2, 1, 0), 0, "R9", h);
    // R12: reset drops dirty contents
    fwd = 32'h0BAD_F00D;
    access(1, mk(6, 3, 0, 0), fwd, "R12", h);
    repeat (30) @(negedge clk);
    w0 = wr_cnt;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #0.5;
    chk(!cpu_req_ready && !mem_rd_req && !mem_wr_req, "R12", "idle outputs in reset",
        {cpu_req_ready, mem_rd_req, mem_wr_req}, 0);
    @(negedge clk); rst_n = 1;
    model_clear();
    repeat (4) @(negedge clk);
    access(0, mk(6, 3, 0, 0), 0, "R12", h);
    chk(!h, "R12", "miss after reset", h, 0);
    access(0, mk(1, 1, 0, 0), 0, "R12", h);
    repeat (10) @(negedge clk);
    chk(wr_cnt == w0, "R12", "dirty data not written after reset", wr_cnt, w0);

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      int sets_pick [4] = '{0, 1, 2, 63};
      int tg = int'($urandom % 6);
      int se = sets_pick[$urandom % 4];
      bit we = ($urandom % 3) == 0;
      access(we, mk(tg, se, int'($urandom % 4), int'($urandom % 4)), $urandom, "R1", h);
    end
    repeat (40) @(negedge clk);
    chk(q_addr.size() == 0, "R8", "all dirty victims written", q_addr.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule